// File: doc/BRIEF.md
# BCD Calendar Counter

This block keeps wall-clock time and calendar date as eight cascaded packed-BCD fields: seconds, minutes, hours (24-hour), day of week, date, month, year and century. Each field stores a tens nibble in bits 7:4 and a units nibble in bits 3:0. A one-cycle `tick` pulse, normally produced once per second by a prescaler elsewhere, advances the seconds. Any carry ripples through every affected field within that same clock cycle.

The date wraps at the length of the current month. February takes 29 days in years divisible by four, and year 00 counts as one of them. The day of week runs beside the date and steps at every midnight. A host can replace all eight fields at once through a parallel load strobe, and a stop input freezes counting. All pins are plain control and data levels. Load is a single-cycle strobe with no back-pressure: it is accepted in every cycle it is high.

Top module: `bcd_calendar`

## Requirements
- R1: Reset (rst_n low) sets seconds, minutes, hours and year to 00, day of week, date and month to 01, and century to the parameter RESET_CENTURY (default 20).
- R2: A tick advances seconds by one in BCD. Seconds and minutes wrap from 59 to 00 and hours from 23 to 00. Each wrap increments the next field in the same cycle.
- R3: The date wraps to 01 and increments the month after day 30 of months 04, 06, 09 and 11, and after day 31 of months 01, 03, 05, 07, 08, 10 and 12.
- R4: In month 02 the date wraps after 29 when the year is divisible by four (00 included), and after 28 otherwise.
- R5: Day of week steps at every hour wrap from 23 to 00, counts 01 to 07, and goes from 07 back to 01.
- R6: Month wraps from 12 to 01 and increments the year. Year wraps from 99 to 00 and increments the century. Century wraps from 39 to 00.
- R7: While `halt` is high, ticks are ignored and every field keeps its value.
- R8: When `load_en` is high, every field takes its slice of `load_time` at the next edge. Load beats both a tick and halt. Slices of `load_time` and `time_out` are [7:0] seconds, [15:8] minutes, [23:16] hours, [31:24] day of week, [39:32] date, [47:40] month, [55:48] year and [63:56] century.
- R9: A cycle with no tick and no load leaves every field unchanged.
- R10: A field loaded above its limit, such as date 31 in month 04, wraps to its low value on its next carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse, one per second |
| halt | input | 1 | Freezes counting while high |
| load_en | input | 1 | Parallel load strobe |
| load_time | input | 64 | Packed BCD fields to load |
| time_out | output | 64 | Packed BCD current fields |

## Verification
Every field is a register, so every result is due exactly one clock edge after its stimulus. This holds for a single tick, a full carry ripple from seconds to century, a load, and a halted or idle cycle. The driver applies each stimulus on a falling edge and queues the expected 64-bit word at the same moment. The monitor pops and compares one entry shortly after each following rising edge, so each comparison lines up with the single edge that should have produced it.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NFIELDS = 8;
  localparam int FW      = 8;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_WDAY = 3;
  localparam int IDX_DATE = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;
  localparam int IDX_CENT = 7;

  // lowest legal value of each field (wrap target)
  function automatic logic [FW-1:0] field_low(input int idx);
    case (idx)
      IDX_WDAY, IDX_DATE, IDX_MON: return 8'h01;
      default:                     return 8'h00;
    endcase
  endfunction

  // fixed upper limit; the date limit is overridden by the month length
  function automatic logic [FW-1:0] field_max(input int idx);
    case (idx)
      IDX_SEC, IDX_MIN: return 8'h59;
      IDX_HOUR:         return 8'h23;
      IDX_WDAY:         return 8'h07;
      IDX_DATE:         return 8'h31;
      IDX_MON:          return 8'h12;
      IDX_YEAR:         return 8'h99;
      default:          return 8'h39;
    endcase
  endfunction

  function automatic logic [FW-1:0] bcd_inc(input logic [FW-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/cal_month_len.sv
module cal_month_len (
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] last_date
);
  logic leap;

  // divisible by 4 in BCD: even tens -> units 0/4/8, odd tens -> units 2/6
  always_comb begin
    if (year[4]) leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
    else         leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
  end

  always_comb begin
    case (month)
      8'h02:                      last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
      default:                    last_date = 8'h31;
    endcase
  end
endmodule

// File: rtl/cal_field.sv
module cal_field #(
  parameter logic [7:0] LOW = 8'h00,
  parameter logic [7:0] RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  logic [7:0] load_val,
  input  logic       inc,
  input  logic [7:0] limit,
  output logic [7:0] value,
  output logic       wrap
);
  // >= so an out-of-range loaded value still wraps on its next carry-in
  assign wrap = inc && (value >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value <= RST;
    else if (load_en) value <= load_val;
    else if (inc)     value <= wrap ? LOW : cal_pkg::bcd_inc(value);
  end

  assert_field_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !load_en) |=> (value == LOW));

  assert_field_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load_en) |=> $stable(value));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter logic [7:0] RESET_CENTURY = 8'h20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        halt,
  input  logic        load_en,
  input  logic [63:0] load_time,
  output logic [63:0] time_out
);
  import cal_pkg::*;

  logic [FW-1:0] val   [NFIELDS];
  logic [FW-1:0] lim   [NFIELDS];
  logic          inc   [NFIELDS];
  logic          wrap  [NFIELDS];
  logic [FW-1:0] mdays;
  logic          step;

  assign step = tick && !halt;

  cal_month_len u_mlen (
    .month     (val[IDX_MON]),
    .year      (val[IDX_YEAR]),
    .last_date (mdays)
  );

  // carry chain; day of week branches off the hour wrap beside the date
  always_comb begin
    inc[IDX_SEC]  = step;
    inc[IDX_MIN]  = wrap[IDX_SEC];
    inc[IDX_HOUR] = wrap[IDX_MIN];
    inc[IDX_WDAY] = wrap[IDX_HOUR];
    inc[IDX_DATE] = wrap[IDX_HOUR];
    inc[IDX_MON]  = wrap[IDX_DATE];
    inc[IDX_YEAR] = wrap[IDX_MON];
    inc[IDX_CENT] = wrap[IDX_YEAR];
  end

  for (genvar i = 0; i < NFIELDS; i++) begin : g_field
    localparam logic [FW-1:0] LOW_I = field_low(i);
    localparam logic [FW-1:0] RST_I = (i == IDX_CENT) ? RESET_CENTURY : field_low(i);

    if (i == IDX_DATE) begin : g_dyn
      assign lim[i] = mdays;
    end else begin : g_fix
      assign lim[i] = field_max(i);
    end

    cal_field #(.LOW(LOW_I), .RST(RST_I)) u_fld (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_en),
      .load_val (load_time[i*FW +: FW]),
      .inc      (inc[i]),
      .limit    (lim[i]),
      .value    (val[i]),
      .wrap     (wrap[i])
    );

    assign time_out[i*FW +: FW] = val[i];
  end

  assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !load_en) |=> $stable(time_out));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (time_out == $past(load_time)));

  assert_sec_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en && time_out[7:0] == 8'h59) |=> (time_out[7:0] == 8'h00));
endmodule

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        halt = 1'b0;
  logic        load_en = 1'b0;
  logic [63:0] load_time = '0;
  logic [63:0] time_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] ref_t;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt),
    .load_en(load_en), .load_time(load_time), .time_out(time_out)
  );

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [63:0] mk(input int c, y, mo, d, w, h, m, s);
    return {i2b(c), i2b(y), i2b(mo), i2b(d), i2b(w), i2b(h), i2b(m), i2b(s)};
  endfunction

  // reference model written from the requirements in integer arithmetic
  function automatic logic [63:0] ref_next(input logic [63:0] t);
    int s, m, h, w, d, mo, y, c, dim;
    s = b2i(t[7:0]);   m = b2i(t[15:8]);  h = b2i(t[23:16]); w = b2i(t[31:24]);
    d = b2i(t[39:32]); mo = b2i(t[47:40]); y = b2i(t[55:48]); c = b2i(t[63:56]);
    if (mo == 2) dim = (y % 4 == 0) ? 29 : 28;
    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) dim = 30;
    else dim = 31;
    if (s < 59) s++;
    else begin
      s = 0;
      if (m < 59) m++;
      else begin
        m = 0;
        if (h < 23) h++;
        else begin
          h = 0;
          w = (w >= 7) ? 1 : w + 1;
          if (d < dim) d++;
          else begin
            d = 1;
            if (mo < 12) mo++;
            else begin
              mo = 1;
              if (y < 99) y++;
              else begin
                y = 0;
                c = (c >= 39) ? 0 : c + 1;
              end
            end
          end
        end
      end
    end
    return mk(c, y, mo, d, w, h, m, s);
  endfunction

  task automatic step(input bit tk, input bit hl, input bit ld,
                      input logic [63:0] lv, input string tag);
    @(negedge clk);
    tick = tk; halt = hl; load_en = ld; load_time = lv;
    if (ld) ref_t = lv;
    else if (tk && !hl) ref_t = ref_next(ref_t);
    exp_q.push_back(ref_t);
    tag_q.push_back(tag);
  endtask

  // monitor: each queued word is due one edge after it was driven
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [63:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      n_cmp++;
      if (time_out !== e) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", tg, time_out, e);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (time_out !== mk(20, 0, 1, 1, 1, 0, 0, 0)) begin
      n_bad++;
      $display("FAIL R1 actual=%h expected=%h", time_out, mk(20, 0, 1, 1, 1, 0, 0, 0));
    end
    ref_t = time_out;
    rst_n = 1'b1;

    // R2: plain ticks, R9: idle cycles
    step(1, 0, 0, '0, "R2");
    step(1, 0, 0, '0, "R2");
    step(0, 0, 0, '0, "R9");
    step(0, 0, 0, '0, "R9");
    // R2: minute and hour carries over a long run
    step(0, 0, 1, mk(20, 25, 6, 14, 3, 12, 58, 40), "R8");
    for (int k = 0; k < 90; k++) step(1, 0, 0, '0, "R2");
    // R3, R5: 30-day month end, weekday 07 -> 01
    step(0, 0, 1, mk(20, 23, 4, 30, 7, 23, 59, 59), "R8");
    step(1, 0, 0, '0, "R3");
    // R3: 31-day month end into February
    step(0, 0, 1, mk(20, 23, 1, 31, 2, 23, 59, 59), "R8");
    step(1, 0, 0, '0, "R3");
    // R3: day 30 of a 31-day month does not wrap
    step(0, 0, 1, mk(20, 23, 7, 30, 4, 23, 59, 59), "R8");
    step(1, 0, 0, '0, "R3");
    // R4: leap and common February
    step(0, 0, 1, mk(20, 24, 2, 28, 3, 23, 59, 59), "R8");
    step(1, 0, 0, '0, "R4");
    for (int k = 0; k < 86400; k += 3600) begin
      if (k == 0) step(0, 0, 1, mk(20, 24, 2, 29, 4, 23, 59, 59), "R8");
    end
    step(1, 0, 0, '0, "R4");
    step(0, 0, 1, mk(20, 23, 2, 28, 5, 23, 59, 59), "R8");
    step(1, 0, 0, '0, "R4");
    step(0, 0, 1, mk(21, 0, 2, 28, 6, 23, 59, 59), "R8");
    step(1, 0, 0, '0, "R4");
    step(0, 0, 1, mk(20, 36, 2, 28, 1, 23, 59, 59), "R8");
    step(1, 0, 0, '0, "R4");
    // R6: full ripple to century and century wrap
    step(0, 0, 1, mk(19, 99, 12, 31, 5, 23, 59, 59), "R8");
    step(1, 0, 0, '0, "R6");
    step(0, 0, 1, mk(39, 99, 12, 31, 6, 23, 59, 59), "R8");
    step(1, 0, 0, '0, "R6");
    // R7: halt ignores ticks
    step(1, 1, 0, '0, "R7");
    step(1, 1, 0, '0, "R7");
    step(0, 1, 0, '0, "R7");
    step(1, 0, 0, '0, "R2");
    // R8: load beats a tick and beats halt
    step(1, 0, 1, mk(20, 50, 8, 15, 2, 10, 20, 30), "R8");
    step(1, 1, 1, mk(20, 51, 9, 16, 3, 11, 21, 31), "R8");
    // R10: out-of-range date wraps on next carry
    step(0, 0, 1, mk(20, 23, 4, 31, 2, 23, 59, 59), "R8");
    step(1, 0, 0, '0, "R10");
    step(0, 0, 0, '0, "R9");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule